// File: doc/BRIEF.md
# Serial Audio Stream Packer

This block takes a two-channel serial audio input and turns it into a stream of one-word packets. The input is sampled on a bit clock running at 64 times the audio sample rate, alongside a word-select line and a data-enable qualifier. Word select stays at one level for 32 enabled bit times and at the other level for the next 32. Each 32-slot half is one channel's subframe. A subframe holds a 24-bit sample and three side bits: validity, user and channel status.

When a complete subframe has been received, the block pushes it into a small FIFO as a single entry. The entry carries the sample, the side bits, the channel number and the current position inside a 192-frame status block. The FIFO output is a ready/valid stream. Every beat is a packet of its own. A downstream consumer can therefore interleave or split the two channels without any further framing. A block-start input puts the frame position back to zero. Parity is not stored: it is generated again on the way out.

Top module: `serial_audio_packer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `overflow` are both 0.
- R2: Within a half, slot k is the k-th enabled bit after a word-select change, counting from 0. Slots 4 to 27 carry the sample least significant bit first, and slot 4 lands in `out_data[0]`. Slots 0 to 3 have no effect on the output.
- R3: The bits in slots 28, 29 and 30 come out on `out_v`, `out_u` and `out_c` respectively. The incoming bit in slot 31 has no effect on any output.
- R4: A half received with word select low is channel 1 and comes out with `out_chan` = 0. A half received with word select high is channel 2 and comes out with `out_chan` = 1.
- R5: Every beat is a complete packet: `out_sop` and `out_eop` are both 1 whenever `out_valid` is 1.
- R6: `out_p` is even parity: the total count of ones in `out_data`, `out_v`, `out_u`, `out_c` and `out_p` is even.
- R7: A cycle with `den_in` low is not a slot. Word select, data and block start are ignored in such a cycle, so toggling word select there creates no edge.
- R8: A word-select change before slot 31 restarts the slot count at 0. The unfinished subframe is discarded and produces no beat.
- R9: The frame position advances by one at each channel-1 start, wrapping from 191 to 0. Both subframes of a frame carry the same value on `out_frame`.
- R10: `blk_start_in` high on the first enabled cycle of a channel-1 half sets that frame's position to 0. At any other time it has no effect.
- R11: Beats leave in arrival order. While `out_valid` is high and `out_ready` is low, `out_valid` and every beat field hold steady.
- R12: The FIFO holds 2^FIFO_AW entries (16 by default). A subframe that completes while the FIFO is full is dropped and never emitted. `overflow` then goes to 1 and stays at 1 until reset.
- R13: The first frame after reset is numbered 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 64 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_in | input | 1 | Word select: low is channel 1, high is channel 2 |
| sd_in | input | 1 | Serial data, one slot per enabled cycle |
| den_in | input | 1 | Data enable; only cycles with it high are slots |
| blk_start_in | input | 1 | Marks frame 0 of a status block at a channel-1 start |
| out_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | A beat is presented |
| out_data | output | 24 | Audio sample |
| out_chan | output | 1 | 0 for channel 1, 1 for channel 2 |
| out_v | output | 1 | Validity bit |
| out_u | output | 1 | User bit |
| out_c | output | 1 | Channel-status bit |
| out_p | output | 1 | Regenerated even parity |
| out_frame | output | 8 | Frame position in the 192-frame block |
| out_sop | output | 1 | Start of packet |
| out_eop | output | 1 | End of packet |
| overflow | output | 1 | Sticky flag: a subframe was dropped |

## Verification
Single set bits at either end of the sample word are used to tell least-significant-first capture apart from reversed capture and from a slot off by one. Alternating and all-ones words, each sent with wrong incoming parity and junk in the lead slots, show that parity is regenerated and that the lead slots are ignored. Enable gaps in which word select toggles and junk arrives separate true slots from idle cycles. A half cut short after 20 slots checks that the count restarts and the partial subframe is thrown away. A full 192-frame run with a block-start marker exercises the wrap. A stalled consumer fed more than the FIFO holds then shows which subframes survive, that the presented beat holds, and that the overflow flag stays set.

// File: rtl/serial_audio_packer.sv
`timescale 1ns/1ps
module serial_audio_packer #(
  parameter int SAMPLE_W   = 24,
  parameter int FIFO_AW    = 4,
  parameter int BLOCK_LEN  = 192,
  parameter int HALF_SLOTS = 32,
  parameter int LEAD_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ws_in,
  input  logic                          sd_in,
  input  logic                          den_in,
  input  logic                          blk_start_in,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [SAMPLE_W-1:0]           out_data,
  output logic                          out_chan,
  output logic                          out_v,
  output logic                          out_u,
  output logic                          out_c,
  output logic                          out_p,
  output logic [$clog2(BLOCK_LEN)-1:0]  out_frame,
  output logic                          out_sop,
  output logic                          out_eop,
  output logic                          overflow
);
  localparam int SW    = $clog2(HALF_SLOTS);
  localparam int FW    = $clog2(BLOCK_LEN);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int CW    = FIFO_AW + 1;
  localparam int EW    = SAMPLE_W + FW + 4;

  localparam logic [SW-1:0] SL_D0 = SW'(LEAD_SLOTS);
  localparam logic [SW-1:0] SL_DL = SW'(LEAD_SLOTS + SAMPLE_W - 1);
  localparam logic [SW-1:0] SL_V  = SW'(LEAD_SLOTS + SAMPLE_W);
  localparam logic [SW-1:0] SL_U  = SW'(LEAD_SLOTS + SAMPLE_W + 1);
  localparam logic [SW-1:0] SL_C  = SW'(LEAD_SLOTS + SAMPLE_W + 2);
  localparam logic [SW-1:0] SL_P  = SW'(LEAD_SLOTS + SAMPLE_W + 3);
  localparam logic [FW-1:0] FR_LAST = FW'(BLOCK_LEN - 1);

  logic                ws_q, locked_q;
  logic [SW-1:0]       slot_q;
  logic [FW-1:0]       frame_q;
  logic [SAMPLE_W-1:0] smp_q;
  logic                v_q, u_q, c_q;

  logic [EW-1:0]       mem [DEPTH];
  logic [FIFO_AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]       fifo_cnt;

  wire ws_edge  = den_in && (ws_in != ws_q);
  wire [SW-1:0] slot_w = ws_edge ? '0 : slot_q + 1'b1;
  wire locked_w = locked_q || ws_edge;
  wire ch1_start = ws_edge && !ws_in;
  wire in_data  = (slot_w >= SL_D0) && (slot_w <= SL_DL);
  wire push     = den_in && locked_w && (slot_w == SL_P);
  wire full     = (fifo_cnt == CW'(DEPTH));
  wire wr       = push && !full;
  wire pop      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q     <= 1'b1;
      locked_q <= 1'b0;
      slot_q   <= '0;
      frame_q  <= FR_LAST;
      smp_q    <= '0;
      v_q      <= 1'b0;
      u_q      <= 1'b0;
      c_q      <= 1'b0;
    end else if (den_in) begin
      ws_q     <= ws_in;
      locked_q <= locked_w;
      slot_q   <= slot_w;
      if (ch1_start)
        frame_q <= (blk_start_in || frame_q == FR_LAST) ? '0 : frame_q + 1'b1;
      if (in_data)
        smp_q <= {sd_in, smp_q[SAMPLE_W-1:1]};
      if (slot_w == SL_V) v_q <= sd_in;
      if (slot_w == SL_U) u_q <= sd_in;
      if (slot_w == SL_C) c_q <= sd_in;
    end
  end

  always_ff @(posedge clk) begin
    if (wr)
      mem[wr_ptr] <= {ws_in, v_q, u_q, c_q, frame_q, smp_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fifo_cnt <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr)  wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      fifo_cnt <= fifo_cnt + CW'(wr) - CW'(pop);
      if (push && full) overflow <= 1'b1;
    end
  end

  assign out_valid = (fifo_cnt != '0);
  assign {out_chan, out_v, out_u, out_c, out_frame, out_data} = mem[rd_ptr];
  assign out_p   = ^{out_data, out_v, out_u, out_c};
  assign out_sop = out_valid;
  assign out_eop = out_valid;
endmodule

// File: rtl/serial_audio_packer_checker.sv
`timescale 1ns/1ps
module serial_audio_packer_checker #(
  parameter int SAMPLE_W  = 24,
  parameter int FIFO_AW   = 4,
  parameter int BLOCK_LEN = 192
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [SAMPLE_W-1:0]          out_data,
  input logic                         out_chan,
  input logic [$clog2(BLOCK_LEN)-1:0] out_frame,
  input logic                         overflow,
  input logic [FIFO_AW:0]             fifo_cnt
);
  localparam int DEPTH = 1 << FIFO_AW;

  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_chan) && $stable(out_frame));

  assert_sticky_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_fill_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);

  assert_frame_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_frame) < BLOCK_LEN);
endmodule

bind serial_audio_packer serial_audio_packer_checker #(
  .SAMPLE_W(SAMPLE_W), .FIFO_AW(FIFO_AW), .BLOCK_LEN(BLOCK_LEN)
) u_checker (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_chan(out_chan), .out_frame(out_frame),
  .overflow(overflow), .fifo_cnt(fifo_cnt)
);

// File: tb/serial_audio_packer_bench.sv
`timescale 1ns/1ps
module serial_audio_packer_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ws, sd, den, blk, ready;
  logic out_valid, out_chan, out_v, out_u, out_c, out_p, out_sop, out_eop, overflow;
  logic [23:0] out_data;
  logic [7:0]  out_frame;

  serial_audio_packer u_serial_audio_packer (
    .clk(clk), .rst_n(rst_n), .ws_in(ws), .sd_in(sd), .den_in(den),
    .blk_start_in(blk), .out_ready(ready), .out_valid(out_valid),
    .out_data(out_data), .out_chan(out_chan), .out_v(out_v), .out_u(out_u),
    .out_c(out_c), .out_p(out_p), .out_frame(out_frame), .out_sop(out_sop),
    .out_eop(out_eop), .overflow(overflow)
  );

  typedef struct {
    logic [23:0] d;
    logic ch, v, u, c;
    int   fr;
    string tag;
  } beat_t;

  beat_t q[$];
  int checks = 0, fails = 0, fr_model = 191;
  bit first_seen = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitout(input logic w, input logic d, input logic e, input logic b);
    @(negedge clk);
    ws = w; sd = d; den = e; blk = b;
  endtask

  task automatic subframe(input logic ch, input logic [23:0] d, input logic v, input logic u,
                          input logic c, input int nslots, input bit bstart, input int gaps,
                          input bit expect_it, input string tag);
    logic [31:0] bits;
    beat_t e;
    if (ch == 1'b0) fr_model = bstart ? 0 : (fr_model == 191 ? 0 : fr_model + 1);
    bits = {~(^{d, v, u, c}), c, u, v, d, 4'b1101};
    if (expect_it && nslots == 32) begin
      e.d = d; e.ch = ch; e.v = v; e.u = u; e.c = c; e.fr = fr_model; e.tag = tag;
      q.push_back(e);
    end
    for (int k = 0; k < nslots; k++) begin
      bitout(ch, bits[k], 1'b1, bstart && k == 0);
      if (gaps > 0 && k % 5 == 2)
        for (int g = 0; g < gaps; g++) bitout(~ch, ~bits[k], 1'b0, 1'b1);
    end
  endtask

  task automatic frame(input logic [23:0] d1, input logic [23:0] d2, input logic [2:0] s1,
                       input logic [2:0] s2, input bit bstart, input int gaps, input string tag);
    subframe(1'b0, d1, s1[2], s1[1], s1[0], 32, bstart, gaps, 1'b1, tag);
    subframe(1'b1, d2, s2[2], s2[1], s2[0], 32, 1'b0, gaps, 1'b1, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) bitout(ws, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R12 unexpected beat", {40'h0, out_data}, 64'h0);
      end else begin
        beat_t e;
        e = q.pop_front();
        check(out_data === e.d, {e.tag, "/R2 sample"}, {40'h0, out_data}, {40'h0, e.d});
        check({out_v, out_u, out_c} === {e.v, e.u, e.c}, {e.tag, "/R3 side bits"},
              {61'h0, out_v, out_u, out_c}, {61'h0, e.v, e.u, e.c});
        check(out_chan === e.ch, {e.tag, "/R4 channel"}, {63'h0, out_chan}, {63'h0, e.ch});
        check(out_sop === 1'b1 && out_eop === 1'b1, "R5 sop/eop",
              {62'h0, out_sop, out_eop}, 64'h3);
        check(out_p === ^{e.d, e.v, e.u, e.c}, "R6 parity", {63'h0, out_p},
              {63'h0, ^{e.d, e.v, e.u, e.c}});
        check(int'(out_frame) == e.fr, {e.tag, "/R9 frame"}, {56'h0, out_frame}, 64'(e.fr));
        if (!first_seen) begin
          first_seen = 1;
          check(out_frame === 8'd0, "R13 first frame", {56'h0, out_frame}, 64'h0);
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; ws = 1; sd = 0; den = 0; blk = 0; ready = 1;
    repeat (5) @(negedge clk);
    check(out_valid === 1'b0, "R1 valid in reset", {63'h0, out_valid}, 64'h0);
    check(overflow === 1'b0, "R1 overflow in reset", {63'h0, overflow}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0 && overflow === 1'b0, "R1 after reset",
          {62'h0, out_valid, overflow}, 64'h0);
    idle(3);

    // R2 R3 R4 R13: bit-order patterns, side bit mixes, wrong incoming parity
    frame(24'h000001, 24'h800000, 3'b100, 3'b011, 0, 0, "R2");
    frame(24'hA5F00F, 24'h5A0FF0, 3'b010, 3'b101, 0, 0, "R3");
    frame(24'hFFFFFF, 24'h000000, 3'b111, 3'b000, 0, 0, "R4");
    // R7: enable gaps with word select toggling and junk data
    frame(24'h13579B, 24'hECA864, 3'b001, 3'b110, 0, 3, "R7");
    // R8: truncated half discarded, slot count restarts
    subframe(1'b0, 24'h123456, 1, 1, 1, 20, 0, 0, 1'b0, "R8");
    subframe(1'b1, 24'h654321, 0, 1, 0, 32, 0, 0, 1'b1, "R8");
    frame(24'h0F0F0F, 24'hF0F0F0, 3'b101, 3'b010, 0, 0, "R8");
    idle(4);
    drain();

    // R10: block start at channel-1 start resets, ignored at channel-2 start
    subframe(1'b0, 24'h222222, 0, 0, 1, 32, 1, 0, 1'b1, "R10");
    subframe(1'b1, 24'h333333, 1, 0, 0, 32, 1, 0, 1'b1, "R10");
    // R9: run the full block to reach 191 and wrap to 0
    for (int f = 0; f < 192; f++)
      frame(24'(f * 4099), 24'(~(f * 257)), 3'(f), 3'(f + 3), 0, 0, "R9");
    idle(4);
    drain();
    check(overflow === 1'b0, "R12 no spurious overflow", {63'h0, overflow}, 64'h0);

    // R11 R12: stalled consumer, more subframes than the FIFO holds
    @(posedge clk); #1 ready = 0;
    for (int f = 0; f < 9; f++) begin
      subframe(1'b0, 24'(24'h100 + f), 1, 0, 0, 32, 0, 0, 1'(2 * f < DEPTH), "R12");
      subframe(1'b1, 24'(24'h200 + f), 0, 0, 1, 32, 0, 0, 1'(2 * f + 1 < DEPTH), "R12");
    end
    idle(5);
    check(out_valid === 1'b1, "R11 valid held", {63'h0, out_valid}, 64'h1);
    check(out_data === q[0].d, "R11 head held", {40'h0, out_data}, {40'h0, q[0].d});
    check(overflow === 1'b1, "R12 overflow set", {63'h0, overflow}, 64'h1);
    @(posedge clk); #1 ready = 1;
    drain();
    check(out_valid === 1'b0, "R12 dropped beats absent", {63'h0, out_valid}, 64'h0);
    check(overflow === 1'b1, "R12 overflow sticky", {63'h0, overflow}, 64'h1);
    check(q.size() == 0, "R11 all beats delivered", 64'(q.size()), 64'h0);

    summary();
    $finish;
  end
endmodule